// File: doc/BRIEF.md
# DMA Engine Lifecycle Controller

This block sequences a send-DMA engine through its whole life: powered down, waiting for hardware start-up, idle, running, waiting for a halt, waiting for hardware clean-up and waiting for software clean-up. Software and hardware report progress as one-cycle event pulses on an eleven-bit event vector. The controller answers each accepted event with a new state and with four registered control levels for the engine: enable, interrupt enable, halt and drain.

A sticky "go running" flag records a run request that arrives while the engine cannot yet run. When a hardware start-up completes, this flag decides whether the engine lands in idle or in running. The controller does no clean-up work itself. Instead it raises one-cycle request strobes for hardware start-up, hardware clean-up and software clean-up, plus a teardown-complete notice, and it waits for the matching completion events. Two distinct error-halt events give two recovery paths: one goes straight to software clean-up, the other goes through the halt wait. Two debug outputs hold the previous state and the index of the last event that took effect.

Top module: `dlc_ctrl`

## Requirements
- R1: After reset the state is powered-down (code 0), all four control outputs and all four strobes are 0, the run flag is 0, the previous-state output is 0 and the last-event output is 15.
- R2: In powered-down, start (bit 1) moves to start-up wait (code 1). Go-running (bit 3) does the same and also sets the run flag. Sw-cleaned (bit 4) raises the teardown-complete strobe and leaves the state as it is.
- R3: In start-up wait, hw-started (bit 2) moves to running (code 6) when the run flag is 1, and to idle (code 2) when it is 0.
- R4: In start-up wait, idle, sw-clean wait (code 3), hw-clean wait (code 4) and halt wait (code 5), go-running sets the run flag and go-idle (bit 7) clears it. Neither changes the state, except that go-running in idle moves to running.
- R5: In running, go-idle moves to halt wait and clears the flag. Error-halt A (bit 8) moves to sw-clean wait with a software clean-up request. Error-halt B (bit 9) moves to halt wait with no request. Hw-halted (bit 6) moves to sw-clean wait with a software clean-up request.
- R6: Hw-halted in halt wait moves to hw-clean wait and requests hardware clean-up. Hw-cleaned (bit 5) in hw-clean wait moves to sw-clean wait and requests software clean-up. Sw-cleaned in sw-clean wait moves to start-up wait and requests hardware start-up.
- R7: Go-down (bit 0) moves to powered-down from every other state. It raises teardown-complete from start-up wait or idle, requests software clean-up from running, halt wait or hw-clean wait, and raises no strobe from sw-clean wait. The run flag is kept.
- R8: Every state/event pair not listed, including every timer tick (bit 10), changes neither the state, the flag, the strobes nor the debug outputs.
- R9: The control outputs {enable, irq enable, halt, drain} are 1100 in running, 0011 in halt wait, 0010 in both clean-up waits and 0000 elsewhere. They change on the same clock edge as the state.
- R10: Strobes {teardown-complete, sw clean-up, hw clean-up, hw start-up} appear on the clock edge that takes the event, last exactly one cycle, and at most one is high at a time.
- R11: When several event bits are high in one cycle, only the lowest-numbered one is considered and the others are dropped, even when the chosen one is ignored in the current state.
- R12: The previous-state output holds the state code before the most recent state change. The last-event output holds the index of the most recent event that took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | One-cycle event pulses, bit index = event number |
| eng_en_o | output | 1 | Engine enable |
| eng_irq_en_o | output | 1 | Engine interrupt enable |
| eng_halt_o | output | 1 | Engine halt |
| eng_drain_o | output | 1 | Engine drain |
| go_run_o | output | 1 | Sticky run-request flag |
| start_req_o | output | 1 | Hardware start-up request strobe |
| hwclean_req_o | output | 1 | Hardware clean-up request strobe |
| swclean_req_o | output | 1 | Software clean-up request strobe |
| down_done_o | output | 1 | Teardown-complete strobe |
| state_o | output | 3 | Current state code |
| prev_state_o | output | 3 | Debug: state before last change |
| last_evt_o | output | 4 | Debug: last effective event index |

## Verification
The flag is exercised by setting it and clearing it in start-up wait, then completing start-up. The two outcomes, idle and running, show that the deferred request is honoured and that go-idle withdraws it. Both error-halt events are driven from running, so the direct recovery path and the halt-wait path can be told apart by the strobe they raise and the state they reach. Go-down is applied from each class of state, which separates the three teardown flavours: notice, clean-up request and silent. Ticks, repeated run requests and simultaneous pulses are mixed in to show that ignored or losing events leave the state, the strobes and the debug outputs untouched.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  localparam int EVT_N = 11;
  localparam int EVW   = $clog2(EVT_N + 1);
  localparam int STW   = 3;

  typedef enum logic [STW-1:0] {
    ST_DOWN   = 3'd0,
    ST_STARTW = 3'd1,
    ST_IDLE   = 3'd2,
    ST_SWCLN  = 3'd3,
    ST_HWCLN  = 3'd4,
    ST_HALTW  = 3'd5,
    ST_RUN    = 3'd6
  } dlc_state_e;

  // event numbers; lower number has priority
  localparam logic [EVW-1:0] EV_GO_DOWN  = EVW'(0);
  localparam logic [EVW-1:0] EV_GO_START = EVW'(1);
  localparam logic [EVW-1:0] EV_STARTED  = EVW'(2);
  localparam logic [EVW-1:0] EV_GO_RUN   = EVW'(3);
  localparam logic [EVW-1:0] EV_SW_CLEAN = EVW'(4);
  localparam logic [EVW-1:0] EV_HW_CLEAN = EVW'(5);
  localparam logic [EVW-1:0] EV_HALTED   = EVW'(6);
  localparam logic [EVW-1:0] EV_GO_IDLE  = EVW'(7);
  localparam logic [EVW-1:0] EV_ERR_A    = EVW'(8);
  localparam logic [EVW-1:0] EV_ERR_B    = EVW'(9);
  localparam logic [EVW-1:0] EV_TICK     = EVW'(10);
  localparam logic [EVW-1:0] EV_NONE     = '1;

  typedef struct packed {
    logic en;
    logic irq;
    logic halt;
    logic drain;
  } dlc_ctrl_t;

  typedef struct packed {
    logic done;
    logic swcl;
    logic hwcl;
    logic start;
  } dlc_strb_t;

endpackage

// File: rtl/dlc_evt_pick.sv
module dlc_evt_pick #(
  parameter int N   = 11,
  parameter int IW  = $clog2(N + 1)
) (
  input  logic [N-1:0]  evt_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (evt_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R11: winner is a raised bit with no raised bit below it
  always_comb begin
    if (valid_o) begin
      lowest_win_chk: assert (evt_i[idx_o] &&
        ((evt_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end

endmodule

// File: rtl/dlc_xition.sv
module dlc_xition
  import dlc_pkg::*;
(
  input  dlc_state_e       cur_i,
  input  logic             flag_i,
  input  logic             valid_i,
  input  logic [EVW-1:0]   idx_i,
  output dlc_state_e       nxt_o,
  output logic             flag_o,
  output dlc_strb_t        strb_o,
  output logic             hit_o
);

  logic waiting;

  always_comb begin
    waiting = (cur_i != ST_DOWN) && (cur_i != ST_RUN);
    nxt_o   = cur_i;
    flag_o  = flag_i;
    strb_o  = '0;
    hit_o   = 1'b0;
    if (valid_i) begin
      unique case (cur_i)
        ST_DOWN: begin
          if (idx_i == EV_GO_START) begin
            nxt_o = ST_STARTW; hit_o = 1'b1;
          end else if (idx_i == EV_GO_RUN) begin
            nxt_o = ST_STARTW; flag_o = 1'b1; hit_o = 1'b1;
          end else if (idx_i == EV_SW_CLEAN) begin
            strb_o.done = 1'b1; hit_o = 1'b1;
          end
        end
        ST_STARTW: begin
          if (idx_i == EV_STARTED) begin
            nxt_o = flag_i ? ST_RUN : ST_IDLE; hit_o = 1'b1;
          end else if (idx_i == EV_GO_DOWN) begin
            nxt_o = ST_DOWN; strb_o.done = 1'b1; hit_o = 1'b1;
          end
        end
        ST_IDLE: begin
          if (idx_i == EV_GO_RUN) begin
            nxt_o = ST_RUN; flag_o = 1'b1; hit_o = 1'b1;
          end else if (idx_i == EV_GO_DOWN) begin
            nxt_o = ST_DOWN; strb_o.done = 1'b1; hit_o = 1'b1;
          end
        end
        ST_RUN: begin
          if (idx_i == EV_GO_IDLE) begin
            nxt_o = ST_HALTW; flag_o = 1'b0; hit_o = 1'b1;
          end else if (idx_i == EV_ERR_A || idx_i == EV_HALTED) begin
            nxt_o = ST_SWCLN; strb_o.swcl = 1'b1; hit_o = 1'b1;
          end else if (idx_i == EV_ERR_B) begin
            nxt_o = ST_HALTW; hit_o = 1'b1;
          end else if (idx_i == EV_GO_DOWN) begin
            nxt_o = ST_DOWN; strb_o.swcl = 1'b1; hit_o = 1'b1;
          end
        end
        ST_HALTW: begin
          if (idx_i == EV_HALTED) begin
            nxt_o = ST_HWCLN; strb_o.hwcl = 1'b1; hit_o = 1'b1;
          end else if (idx_i == EV_GO_DOWN) begin
            nxt_o = ST_DOWN; strb_o.swcl = 1'b1; hit_o = 1'b1;
          end
        end
        ST_HWCLN: begin
          if (idx_i == EV_HW_CLEAN) begin
            nxt_o = ST_SWCLN; strb_o.swcl = 1'b1; hit_o = 1'b1;
          end else if (idx_i == EV_GO_DOWN) begin
            nxt_o = ST_DOWN; strb_o.swcl = 1'b1; hit_o = 1'b1;
          end
        end
        ST_SWCLN: begin
          if (idx_i == EV_SW_CLEAN) begin
            nxt_o = ST_STARTW; strb_o.start = 1'b1; hit_o = 1'b1;
          end else if (idx_i == EV_GO_DOWN) begin
            nxt_o = ST_DOWN; hit_o = 1'b1;
          end
        end
        default: begin
          nxt_o = ST_DOWN;
        end
      endcase
      // flag edits that leave the state alone
      if (waiting && cur_i != ST_IDLE && idx_i == EV_GO_RUN) begin
        flag_o = 1'b1; hit_o = 1'b1;
      end
      if (waiting && idx_i == EV_GO_IDLE) begin
        flag_o = 1'b0; hit_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dlc_ctrl_tbl.sv
module dlc_ctrl_tbl
  import dlc_pkg::*;
#(
  parameter bit HALT_IN_CLEAN = 1'b1
) (
  input  dlc_state_e st_i,
  output dlc_ctrl_t  ctrl_o
);

  logic clean_halt;

  generate
    if (HALT_IN_CLEAN) begin : g_hold
      assign clean_halt = (st_i == ST_SWCLN) || (st_i == ST_HWCLN);
    end else begin : g_free
      assign clean_halt = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_o = '0;
    unique case (st_i)
      ST_RUN:   begin ctrl_o.en = 1'b1; ctrl_o.irq = 1'b1; end
      ST_HALTW: begin ctrl_o.halt = 1'b1; ctrl_o.drain = 1'b1; end
      default:  ctrl_o.halt = clean_halt;
    endcase
  end

endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
  import dlc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_N-1:0]     evt_i,
  output logic                 eng_en_o,
  output logic                 eng_irq_en_o,
  output logic                 eng_halt_o,
  output logic                 eng_drain_o,
  output logic                 go_run_o,
  output logic                 start_req_o,
  output logic                 hwclean_req_o,
  output logic                 swclean_req_o,
  output logic                 down_done_o,
  output logic [STW-1:0]       state_o,
  output logic [STW-1:0]       prev_state_o,
  output logic [EVW-1:0]       last_evt_o
);

  dlc_state_e     state_q, state_d, prev_q, prev_d;
  logic           flag_q, flag_d;
  dlc_ctrl_t      ctrl_q, ctrl_d;
  dlc_strb_t      strb_q, strb_d;
  logic [EVW-1:0] last_q, last_d;

  logic           ev_valid;
  logic [EVW-1:0] ev_idx;
  dlc_state_e     x_nxt;
  logic           x_flag;
  dlc_strb_t      x_strb;
  logic           x_hit;
  dlc_ctrl_t      tbl_ctrl;

  dlc_evt_pick #(.N(EVT_N), .IW(EVW)) u_pick (
    .evt_i   (evt_i),
    .valid_o (ev_valid),
    .idx_o   (ev_idx)
  );

  dlc_xition u_xition (
    .cur_i   (state_q),
    .flag_i  (flag_q),
    .valid_i (ev_valid),
    .idx_i   (ev_idx),
    .nxt_o   (x_nxt),
    .flag_o  (x_flag),
    .strb_o  (x_strb),
    .hit_o   (x_hit)
  );

  dlc_ctrl_tbl #(.HALT_IN_CLEAN(1'b1)) u_tbl (
    .st_i   (x_nxt),
    .ctrl_o (tbl_ctrl)
  );

  // next-state process with explicit enables
  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    ctrl_d  = ctrl_q;
    prev_d  = prev_q;
    last_d  = last_q;
    strb_d  = '0;
    if (x_hit) begin
      state_d = x_nxt;
      flag_d  = x_flag;
      ctrl_d  = tbl_ctrl;
      strb_d  = x_strb;
      last_d  = ev_idx;
      if (x_nxt != state_q) prev_d = state_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DOWN;
      prev_q  <= ST_DOWN;
      flag_q  <= 1'b0;
      ctrl_q  <= '0;
      strb_q  <= '0;
      last_q  <= EV_NONE;
    end else begin
      state_q <= state_d;
      prev_q  <= prev_d;
      flag_q  <= flag_d;
      ctrl_q  <= ctrl_d;
      strb_q  <= strb_d;
      last_q  <= last_d;
    end
  end

  assign eng_en_o      = ctrl_q.en;
  assign eng_irq_en_o  = ctrl_q.irq;
  assign eng_halt_o    = ctrl_q.halt;
  assign eng_drain_o   = ctrl_q.drain;
  assign go_run_o      = flag_q;
  assign start_req_o   = strb_q.start;
  assign hwclean_req_o = strb_q.hwcl;
  assign swclean_req_o = strb_q.swcl;
  assign down_done_o   = strb_q.done;
  assign state_o       = state_q;
  assign prev_state_o  = prev_q;
  assign last_evt_o    = last_q;

  // R10
  strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb_q));

  // R9
  run_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (ctrl_q.en && ctrl_q.irq && !ctrl_q.halt));

  // R9
  halt_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALTW) |-> (ctrl_q.halt && ctrl_q.drain && !ctrl_q.en));

  // R6
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req_o |-> (state_q == ST_STARTW && $past(state_q) == ST_SWCLN));

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    down_done_o |-> (state_q == ST_DOWN));

  // R6
  hwclean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hwclean_req_o |-> (state_q == ST_HWCLN && $past(state_q) == ST_HALTW));

  // R8
  tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == (EVT_N'(1) << EV_TICK)) |=> ($stable(state_q) && strb_q == '0));

endmodule

// File: tb/dlc_ctrl_tb.sv
module dlc_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic        en, irq, halt, drain, flag, st_rq, hw_rq, sw_rq, done;
  logic [2:0]  st, pv;
  logic [3:0]  le;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dlc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .eng_en_o(en), .eng_irq_en_o(irq), .eng_halt_o(halt), .eng_drain_o(drain),
    .go_run_o(flag), .start_req_o(st_rq), .hwclean_req_o(hw_rq),
    .swclean_req_o(sw_rq), .down_done_o(done),
    .state_o(st), .prev_state_o(pv), .last_evt_o(le)
  );

  typedef struct {
    logic [2:0] st;
    logic       fl;
    logic [3:0] sb;
    logic [3:0] le;
    logic [2:0] pv;
    string      tag;
  } exp_t;

  exp_t q[$];

  // R9 table as specified
  function automatic logic [3:0] ctrl_of(logic [2:0] s);
    case (s)
      3'd6:      return 4'b1100;
      3'd5:      return 4'b0011;
      3'd3, 3'd4: return 4'b0010;
      default:   return 4'b0000;
    endcase
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per posedge, samples just after
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "state", st, e.st);
      cmp(e.tag, "ctrl", {en, irq, halt, drain}, ctrl_of(e.st));
      cmp(e.tag, "flag", flag, e.fl);
      cmp(e.tag, "strobes", {done, sw_rq, hw_rq, st_rq}, e.sb);
      cmp(e.tag, "last_evt", le, e.le);
      cmp(e.tag, "prev", pv, e.pv);
    end
  end

  // driver: drive at negedge, expectation applies after next posedge
  task automatic step(logic [10:0] ev, logic [2:0] s, logic f, logic [3:0] sb,
                      logic [3:0] l, logic [2:0] p, string tag);
    exp_t e;
    @(negedge clk);
    evt = ev;
    e.st = s; e.fl = f; e.sb = sb; e.le = l; e.pv = p; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [10:0] b(int i);
    return 11'(1) << i;
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step('0, 0, 0, 4'h0, 15, 0, "R1 reset");
    step(b(10), 0, 0, 4'h0, 15, 0, "R8 tick in down");
    step(b(0) | b(1), 0, 0, 4'h0, 15, 0, "R11 go_down beats start");
    step(b(1), 1, 0, 4'h0, 1, 0, "R2 start");
    step(b(3), 1, 1, 4'h0, 3, 0, "R4 flag set");
    step(b(7), 1, 0, 4'h0, 7, 0, "R4 flag clear");
    step(b(2) | b(3), 2, 0, 4'h0, 2, 1, "R3 R11 started to idle");
    step(b(7), 2, 0, 4'h0, 7, 1, "R4 go_idle in idle");
    step(b(3), 6, 1, 4'h0, 3, 2, "R4 idle to run");
    step(b(3), 6, 1, 4'h0, 3, 2, "R8 go_run in run");
    step(b(10), 6, 1, 4'h0, 3, 2, "R8 tick in run");
    step(b(9), 5, 1, 4'h0, 9, 6, "R5 err B");
    step(b(6), 4, 1, 4'h2, 6, 5, "R6 halted");
    step('0, 4, 1, 4'h0, 6, 5, "R10 strobe width");
    step(b(5), 3, 1, 4'h4, 5, 4, "R6 hw cleaned");
    step(b(4), 1, 1, 4'h1, 4, 3, "R6 sw cleaned");
    step('0, 1, 1, 4'h0, 4, 3, "R10 start width");
    step(b(2), 6, 1, 4'h0, 2, 1, "R3 started to run");
    step(b(8), 3, 1, 4'h4, 8, 6, "R5 err A");
    step(b(7), 3, 0, 4'h0, 7, 6, "R4 clear in swclean");
    step(b(4), 1, 0, 4'h1, 4, 3, "R6 restart");
    step(b(2), 2, 0, 4'h0, 2, 1, "R3 to idle");
    step(b(0), 0, 0, 4'h8, 0, 2, "R7 down from idle");
    step(b(4), 0, 0, 4'h8, 4, 2, "R2 sw cleaned in down");
    step(b(3), 1, 1, 4'h0, 3, 0, "R2 go_run in down");
    step(b(0), 0, 1, 4'h8, 0, 1, "R7 down from startw");
    step(b(1), 1, 1, 4'h0, 1, 0, "R2 start again");
    step(b(2), 6, 1, 4'h0, 2, 1, "R3 run via kept flag");
    step(b(6), 3, 1, 4'h4, 6, 6, "R5 halted in run");
    step(b(0), 0, 1, 4'h0, 0, 3, "R7 silent down");
    step(b(1), 1, 1, 4'h0, 1, 0, "R2 start");
    step(b(2), 6, 1, 4'h0, 2, 1, "R3 run");
    step(b(7), 5, 0, 4'h0, 7, 6, "R5 go_idle in run");
    step(b(0), 0, 0, 4'h4, 0, 5, "R7 down from haltw");
    step(b(7), 0, 0, 4'h0, 0, 5, "R8 go_idle in down");
    step(b(3), 1, 1, 4'h0, 3, 0, "R2 go_run");
    step(b(2), 6, 1, 4'h0, 2, 1, "R3 run");
    step(b(0), 0, 1, 4'h4, 0, 6, "R7 down from run");
    step(b(5), 0, 1, 4'h0, 0, 6, "R8 R12 hw cleaned in down");
    step(b(1), 1, 1, 4'h0, 1, 0, "R12 start");
    step(b(2), 6, 1, 4'h0, 2, 1, "R12 run");
    step(b(9), 5, 1, 4'h0, 9, 6, "R5 err B");
    step(b(6), 4, 1, 4'h2, 6, 5, "R6 halted");
    step(b(0), 0, 1, 4'h4, 0, 4, "R7 down from hwclean");
    @(negedge clk);
    evt = '0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule